// File: doc/BRIEF.md
# I2C Serial EEPROM Slave Controller

This block is the digital core of a serial EEPROM that only ever answers on a two-wire I2C bus. The master owns SCL and creates every START and STOP condition. The block filters both bus lines, finds the bus conditions, and acknowledges its own device address. It then takes a two-byte word address and either writes or reads an internal byte array that stands in for the nonvolatile cells. SDA is never driven high: the block has a single pull-low enable, which the pad turns into an open-drain output.

Writes are gathered into a page buffer. They reach the array only during a modelled internal write cycle, which a STOP starts. While that cycle runs, the block refuses every device address, so a master can poll until it is answered. Three strap inputs select one of eight device identities, so eight parts can share a bus. A protect input guards the upper quarter of the array. Reads can start at the current address, at an address set by a dummy write, or run on sequentially across the whole array.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: SCL and SDA are sampled through a two-stage synchroniser. A level change is accepted only after FILT_LEN consecutive samples that differ from the filtered level, so a one-clock pulse on SCL has no effect on the transfer.
- R2: The first byte after START is the device byte: bits 7:4 must be 1010, bits 3:1 must equal `dev_sel[2:0]`, and bit 0 is the direction (1 = read). On a match the block pulls SDA low for the ACK slot. On any other value it leaves SDA released for that slot and all later bits until the next START.
- R3: A write-direction device byte is followed by the word address, high byte first, then low byte. Only the low ADDR_W bits of the 16-bit value are used; the higher bits are ignored.
- R4: Each data byte of a write is ACKed and stored in the page buffer. After each byte the low PAGE_W address bits increment and wrap inside the 2**PAGE_W-byte page, and the upper bits stay fixed.
- R5: Buffered write data reaches the array only when a STOP follows at least one ACKed data byte. If a START comes first, the buffered data is discarded and no write cycle starts.
- R6: A write cycle lasts TWR_CYC clocks from the STOP. During it every device byte, even a matching one, is NACKed.
- R7: When `wp` is 1, a byte aimed at an address whose two top bits are 11 (upper quarter) is still ACKed but is never stored. When `wp` is 0, the whole array is writable.
- R8: A read returns the byte at the current address. That address is the one after the last byte accessed, or the one set by a preceding word-address write. Each byte sent advances it by one across the whole array, and it wraps from the top address to 0.
- R9: A master NACK after a read byte ends the read. SDA stays released for all further clocks until the next START.
- R10: While SCL is high, `sda_oe` changes only as a result of a START or STOP. In every other case the block alters SDA only while SCL is low.
- R11: After reset, `sda_oe` is 0 and the block waits for a START.
- R12: A START or STOP in the middle of any transfer releases SDA. After a START, the next byte is taken as a device byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| dev_sel | input | 3 | Device identity straps (tie unused bits to 0) |
| wp | input | 1 | 1 protects the upper quarter of the array |

## Verification
Several properties are checked on every cycle. SDA holds still while SCL is high unless a START or STOP intervenes. The block stays silent outside a transfer. A mismatched device byte, or any device byte during a write cycle, leaves the ACK slot released. Page writes never change the upper address bits. The commit counter stays within its window, and no byte loads during a write cycle. Only the bench scenarios can show the data path end to end. These include the contents read back after page wrap, protect, high-bit masking and an aborted write, sequential reads wrapping at the array top, the current-address pointer, busy polling timing, and rejection of glitches. The bench's model predicts the pull-low enable for every SCL-high clock and compares against it.

// File: rtl/eei2c_pkg.sv
package eei2c_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_AHI, ST_ALO, ST_WDAT, ST_RDAT, ST_MACK
  } ee_state_t;
  localparam logic [3:0] DEV_TYPE = 4'b1010;
endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic filt
);
  localparam int CW = $clog2(FILT_LEN + 1);
  logic [1:0]    sync;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync <= 2'b11;
      cnt  <= '0;
      filt <= 1'b1;
    end else begin
      sync <= {sync[0], raw};
      if (sync[1] == filt) begin
        cnt <= '0;
      end else if (cnt == CW'(FILT_LEN - 1)) begin
        filt <= sync[1];
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R1: a filtered transition needs a differing synchronised sample behind it
  a_r1_filter_follows: assert property (@(posedge clk) disable iff (rst)
    !$stable(filt) |-> ($past(sync[1]) != $past(filt)));
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk,
  input  logic rst,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_c,
  output logic stop_c
);
  logic scl_p, sda_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_f;
      sda_p <= sda_f;
    end
  end

  assign scl_rise = ~scl_p & scl_f;
  assign scl_fall = scl_p & ~scl_f;
  assign start_c  = scl_p & scl_f & sda_p & ~sda_f;
  assign stop_c   = scl_p & scl_f & ~sda_p & sda_f;
endmodule

// File: rtl/eeprom_array.sv
module eeprom_array #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/page_commit.sv
module page_commit #(
  parameter int ADDR_W  = 11,
  parameter int PAGE_W  = 5,
  parameter int TWR_CYC = 4000
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load,
  input  logic [PAGE_W-1:0]        load_idx,
  input  logic [7:0]               load_data,
  input  logic                     load_keep,
  input  logic [ADDR_W-PAGE_W-1:0] load_base,
  input  logic                     discard,
  input  logic                     go,
  output logic                     busy,
  output logic                     mem_we,
  output logic [ADDR_W-1:0]        mem_waddr,
  output logic [7:0]               mem_wdata
);
  localparam int PSIZE = 1 << PAGE_W;
  localparam int TW    = $clog2(TWR_CYC + 1);

  logic [7:0]              pbuf [PSIZE];
  logic [PSIZE-1:0]        pvalid;
  logic [ADDR_W-PAGE_W-1:0] base;
  logic                    has_data;
  logic [TW-1:0]           cnt;
  logic [PAGE_W-1:0]       cidx;

  assign cidx      = cnt[PAGE_W-1:0];
  assign mem_we    = busy && (cnt < TW'(PSIZE)) && pvalid[cidx];
  assign mem_waddr = {base, cidx};
  assign mem_wdata = pbuf[cidx];

  always_ff @(posedge clk) begin
    if (load) pbuf[load_idx] <= load_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pvalid   <= '0;
      base     <= '0;
      has_data <= 1'b0;
      busy     <= 1'b0;
      cnt      <= '0;
    end else if (busy) begin
      if (cnt == TW'(TWR_CYC - 1)) begin
        busy     <= 1'b0;
        pvalid   <= '0;
        has_data <= 1'b0;
        cnt      <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else if (discard) begin
      pvalid   <= '0;
      has_data <= 1'b0;
    end else if (go) begin
      if (has_data) busy <= 1'b1;
      cnt <= '0;
    end else if (load) begin
      base             <= load_base;
      has_data         <= 1'b1;
      pvalid[load_idx] <= load_keep;
    end
  end

  // R5: nothing may enter the buffer while it is being committed
  a_r5_no_load_busy: assert property (@(posedge clk) disable iff (rst)
    busy |-> !load);
  // R6: the write-cycle counter stays inside its window
  a_r6_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt < TW'(TWR_CYC)));
endmodule

// File: rtl/eeprom_i2c_slave.sv
module eeprom_i2c_slave
  import eei2c_pkg::*;
#(
  parameter int ADDR_W   = 11,
  parameter int PAGE_W   = 5,
  parameter int FILT_LEN = 3,
  parameter int TWR_CYC  = 4000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [2:0] dev_sel,
  input  logic       wp
);
  localparam int BASE_W = ADDR_W - PAGE_W;

  logic [1:0] raw_v, filt_v;
  logic scl_f, sda_f, scl_rise, scl_fall, start_c, stop_c;

  assign raw_v = {sda_i, scl_i};
  generate
    for (genvar gi = 0; gi < 2; gi++) begin : g_filt
      i2c_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
        .clk(clk), .rst(rst), .raw(raw_v[gi]), .filt(filt_v[gi]));
    end
  endgenerate
  assign scl_f = filt_v[0];
  assign sda_f = filt_v[1];

  i2c_bus_events u_evt (
    .clk(clk), .rst(rst), .scl_f(scl_f), .sda_f(sda_f),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_c(start_c), .stop_c(stop_c));

  ee_state_t         st;
  logic [3:0]        bitcnt;
  logic [7:0]        shreg, hi_byte, rd_q;
  logic              in_ack, rw;
  logic [ADDR_W-1:0] cur_addr;
  logic              busy, mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [7:0]        mem_wdata;
  logic              byte_done, dev_ok, pc_load, protect;
  logic [15:0]       full_addr;

  assign byte_done = scl_fall && !in_ack && (bitcnt == 4'd8);
  assign dev_ok    = (shreg[7:4] == DEV_TYPE) && (shreg[3:1] == dev_sel) && !busy;
  assign pc_load   = (st == ST_WDAT) && byte_done && !start_c && !stop_c;
  assign protect   = wp && (cur_addr[ADDR_W-1 -: 2] == 2'b11);
  assign full_addr = {hi_byte, shreg};

  page_commit #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .TWR_CYC(TWR_CYC)) u_commit (
    .clk(clk), .rst(rst),
    .load(pc_load), .load_idx(cur_addr[PAGE_W-1:0]), .load_data(shreg),
    .load_keep(!protect), .load_base(cur_addr[ADDR_W-1:PAGE_W]),
    .discard(start_c), .go(stop_c), .busy(busy),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata));

  eeprom_array #(.ADDR_W(ADDR_W)) u_array (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(cur_addr), .rdata(rd_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; bitcnt <= '0; shreg <= '0; hi_byte <= '0;
      in_ack <= 1'b0; rw <= 1'b0; cur_addr <= '0; sda_oe <= 1'b0;
    end else if (start_c) begin
      st <= ST_DEV; bitcnt <= '0; in_ack <= 1'b0; sda_oe <= 1'b0;
    end else if (stop_c) begin
      st <= ST_IDLE; in_ack <= 1'b0; sda_oe <= 1'b0;
    end else begin
      unique case (st)
        ST_DEV, ST_AHI, ST_ALO, ST_WDAT: begin
          if (scl_rise && !in_ack) begin
            shreg  <= {shreg[6:0], sda_f};
            bitcnt <= bitcnt + 1'b1;
          end else if (byte_done) begin
            if (st == ST_DEV && !dev_ok) begin
              st <= ST_IDLE;
            end else begin
              in_ack <= 1'b1;
              sda_oe <= 1'b1;
              if (st == ST_DEV) rw <= shreg[0];
              if (st == ST_AHI) hi_byte <= shreg;
              if (st == ST_ALO) cur_addr <= full_addr[ADDR_W-1:0];
              if (st == ST_WDAT)
                cur_addr[PAGE_W-1:0] <= cur_addr[PAGE_W-1:0] + 1'b1;
            end
          end else if (scl_fall && in_ack) begin
            in_ack <= 1'b0;
            bitcnt <= '0;
            sda_oe <= 1'b0;
            if (st == ST_DEV && rw) begin
              st       <= ST_RDAT;
              shreg    <= rd_q;
              sda_oe   <= ~rd_q[7];
              cur_addr <= cur_addr + 1'b1;
            end else if (st == ST_DEV) st <= ST_AHI;
            else if (st == ST_AHI)     st <= ST_ALO;
            else if (st == ST_ALO)     st <= ST_WDAT;
          end
        end
        ST_RDAT: begin
          if (scl_rise) begin
            bitcnt <= bitcnt + 1'b1;
          end else if (scl_fall) begin
            if (bitcnt == 4'd8) begin
              sda_oe <= 1'b0;
              st     <= ST_MACK;
            end else begin
              shreg  <= {shreg[6:0], 1'b0};
              sda_oe <= ~shreg[6];
            end
          end
        end
        ST_MACK: begin
          if (scl_rise && sda_f) begin
            st <= ST_IDLE;
          end else if (scl_fall) begin
            st       <= ST_RDAT;
            bitcnt   <= '0;
            shreg    <= rd_q;
            sda_oe   <= ~rd_q[7];
            cur_addr <= cur_addr + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  // R10: SDA only moves while SCL is low, unless a bus condition forced a release
  a_r10_sda_quiet_high: assert property (@(posedge clk) disable iff (rst)
    (scl_f && $past(scl_f) && !$past(start_c) && !$past(stop_c)) |-> $stable(sda_oe));
  // R9 / R11: outside a transfer the line is never pulled
  a_r9_idle_silent: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE) |-> !sda_oe);
  // R2: a foreign device byte leaves the ACK slot released
  a_r2_foreign_nack: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DEV && byte_done && !start_c && !stop_c &&
     ((shreg[7:4] != DEV_TYPE) || (shreg[3:1] != dev_sel))) |=> !sda_oe);
  // R6: during a write cycle every device byte is refused
  a_r6_busy_nack: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DEV && byte_done && busy && !start_c && !stop_c) |=> !sda_oe);
  // R4: page writes keep the page bits of the address
  a_r4_page_wrap: assert property (@(posedge clk) disable iff (rst)
    $past(pc_load) |-> (cur_addr[ADDR_W-1:PAGE_W] == $past(cur_addr[ADDR_W-1:PAGE_W])));
endmodule

// File: tb/test_eeprom_i2c_slave.sv
module test_eeprom_i2c_slave;
  localparam int AW   = 11;
  localparam int SIZE = 1 << AW;
  localparam int TWR  = 800;
  localparam int Q    = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic scl = 1'b1, sda_m = 1'b1, wp = 1'b0;
  logic [2:0] sel = 3'b101;
  logic sda_oe, sda_bus;
  int vectors = 0, fails = 0, cur = 0;
  bit done = 0;
  logic [7:0] ref_mem [SIZE];

  always #10 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  eeprom_i2c_slave #(.ADDR_W(AW), .PAGE_W(5), .FILT_LEN(3), .TWR_CYC(TWR)) i_eeprom_i2c_slave (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .dev_sel(sel), .wp(wp));

  task automatic waitc(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic bit_cyc(input logic b, input logic exp, input bit glitch, input string tag);
    bit bad = 0;
    scl = 1'b0; waitc(Q);
    sda_m = b; waitc(Q / 2);
    if (glitch) begin scl = 1'b1; waitc(1); scl = 1'b0; end
    waitc(Q / 2);
    scl = 1'b1;
    for (int k = 0; k < 2 * Q; k++) begin
      @(negedge clk);
      vectors++;
      if (sda_oe !== exp && !bad) begin
        bad = 1; fails++;
        $display("FAIL %s/R10: sda_oe=%b expected %b", tag, sda_oe, exp);
      end
    end
    scl = 1'b0;
  endtask

  task automatic wr_byte(input logic [7:0] d, input logic exp_ack, input bit gl, input string tag);
    for (int i = 7; i >= 0; i--) bit_cyc(d[i], 1'b0, gl, tag);
    bit_cyc(1'b1, exp_ack, 1'b0, tag);
  endtask

  task automatic rd_byte(input logic [7:0] e, input bit more, input string tag);
    for (int i = 7; i >= 0; i--) bit_cyc(1'b1, ~e[i], 1'b0, tag);
    bit_cyc(more ? 1'b0 : 1'b1, 1'b0, 1'b0, tag);
  endtask

  task automatic bus_start();
    scl = 1'b0; waitc(Q); sda_m = 1'b1; waitc(Q);
    scl = 1'b1; waitc(Q); sda_m = 1'b0; waitc(Q); scl = 1'b0;
  endtask

  task automatic bus_stop();
    scl = 1'b0; waitc(Q); sda_m = 1'b0; waitc(Q);
    scl = 1'b1; waitc(Q); sda_m = 1'b1; waitc(Q);
  endtask

  function automatic logic [7:0] devb(input logic r);
    return {4'b1010, sel, r};
  endfunction

  task automatic page_write(input logic [7:0] ah, input logic [7:0] al, input int n,
                            input logic [7:0] seed, input bit settle, input string tag);
    int a = int'({ah, al}) & (SIZE - 1);
    int pg = a & ~31;
    bus_start();
    wr_byte(devb(1'b0), 1'b1, 0, tag);
    wr_byte(ah, 1'b1, 0, tag);
    wr_byte(al, 1'b1, 0, tag);
    for (int i = 0; i < n; i++) begin
      int t = pg | ((a + i) & 31);
      wr_byte(seed + 8'(i), 1'b1, 0, tag);
      if (!(wp && t >= 3 * SIZE / 4)) ref_mem[t] = seed + 8'(i);
    end
    cur = pg | ((a + n) & 31);
    bus_stop();
    if (settle) waitc(TWR + 300);
  endtask

  task automatic cur_read(input int n, input string tag);
    bus_start();
    wr_byte(devb(1'b1), 1'b1, 0, tag);
    for (int i = 0; i < n; i++) begin
      rd_byte(ref_mem[cur], i < n - 1, tag);
      cur = (cur + 1) % SIZE;
    end
    bus_stop();
  endtask

  task automatic rand_read(input logic [7:0] ah, input logic [7:0] al, input int n, input string tag);
    bus_start();
    wr_byte(devb(1'b0), 1'b1, 0, tag);
    wr_byte(ah, 1'b1, 0, tag);
    wr_byte(al, 1'b1, 0, tag);
    cur = int'({ah, al}) & (SIZE - 1);
    cur_read(n, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    waitc(190000);
    fails++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    waitc(5); rst = 1'b0; waitc(5);
    @(negedge clk); vectors++;
    if (sda_oe !== 1'b0) begin fails++; $display("FAIL R11: sda_oe=%b expected 0", sda_oe); end

    page_write(8'h00, 8'h10, 4, 8'h30, 1, "R4");
    rand_read(8'h00, 8'h10, 4, "R8");
    page_write(8'h07, 8'hFE, 3, 8'h50, 1, "R4");      // 7FE,7FF then wraps to 7E0
    page_write(8'h00, 8'h00, 1, 8'h77, 1, "R8");
    rand_read(8'h07, 8'hFE, 3, "R8");                 // wraps array top to 0
    rand_read(8'h07, 8'hE0, 1, "R4");
    page_write(8'hF9, 8'h20, 1, 8'hA5, 1, "R3");      // high bits dropped: 0x120
    rand_read(8'h01, 8'h20, 1, "R3");
    page_write(8'h02, 8'h00, 2, 8'h11, 1, "R8");
    rand_read(8'h02, 8'h00, 1, "R8");
    cur_read(1, "R8");                                // current address 0x201

    // R6: poll during write cycle, then after it
    page_write(8'h03, 8'h00, 1, 8'h42, 0, "R6");
    bus_start(); wr_byte(devb(1'b0), 1'b0, 0, "R6"); bus_stop();
    waitc(TWR + 300);
    bus_start(); wr_byte(devb(1'b0), 1'b1, 0, "R6"); bus_stop();
    rand_read(8'h03, 8'h00, 1, "R6");

    // R7: protect
    wp = 1'b1;
    page_write(8'h07, 8'hFF, 1, 8'hEE, 1, "R7");
    rand_read(8'h07, 8'hFF, 1, "R7");
    page_write(8'h01, 8'h50, 1, 8'h66, 1, "R7");
    rand_read(8'h01, 8'h50, 1, "R7");
    wp = 1'b0;
    page_write(8'h06, 8'h00, 1, 8'h99, 1, "R7");
    rand_read(8'h06, 8'h00, 1, "R7");

    // R5 / R12: START aborts a write; no write cycle follows
    bus_start();
    wr_byte(devb(1'b0), 1'b1, 0, "R5");
    wr_byte(8'h01, 1'b1, 0, "R5");
    wr_byte(8'h20, 1'b1, 0, "R5");
    wr_byte(8'hFF, 1'b1, 0, "R5");
    bus_start();
    wr_byte(devb(1'b0), 1'b1, 0, "R12");
    bus_stop();
    bus_start(); wr_byte(devb(1'b0), 1'b1, 0, "R5"); bus_stop();
    rand_read(8'h01, 8'h20, 1, "R5");

    // R2: foreign identity and foreign type bits
    bus_start();
    wr_byte({4'b1010, ~sel, 1'b0}, 1'b0, 0, "R2");
    wr_byte(8'h00, 1'b0, 0, "R2");
    bus_stop();
    bus_start(); wr_byte({4'b1011, sel, 1'b0}, 1'b0, 0, "R2"); bus_stop();
    sel = 3'b010;
    rand_read(8'h00, 8'h11, 1, "R2");

    // R9: master NACK ends the read
    bus_start();
    wr_byte(devb(1'b0), 1'b1, 0, "R9");
    wr_byte(8'h02, 1'b1, 0, "R9");
    wr_byte(8'h00, 1'b1, 0, "R9");
    bus_start();
    wr_byte(devb(1'b1), 1'b1, 0, "R9");
    rd_byte(ref_mem[12'h200], 0, "R9");
    for (int i = 0; i < 9; i++) bit_cyc(1'b1, 1'b0, 0, "R9");
    bus_stop();

    // R1: one-clock SCL pulses inside every low phase are ignored
    bus_start();
    wr_byte(devb(1'b0), 1'b1, 1, "R1");
    wr_byte(8'h04, 1'b1, 1, "R1");
    wr_byte(8'h40, 1'b1, 1, "R1");
    wr_byte(8'hC3, 1'b1, 1, "R1");
    ref_mem[12'h440] = 8'hC3;
    bus_stop();
    waitc(TWR + 300);
    rand_read(8'h04, 8'h40, 1, "R1");

    finish_run();
  end
endmodule